// File: doc/BRIEF.md
# I2C Bus-Busy Monitor

This block watches the clock and data lines of a two-wire I2C bus and keeps a flag that tells a local host whether the bus is in use. Both lines are brought into the system clock domain through a synchroniser. A START condition (data falling while the clock is high) marks the bus as taken. A STOP condition (data rising while the clock is high) marks it as free. Each condition also produces a one-cycle pulse. The host can only read the flag; nothing it does can write it.

The flag is active-low: 0 means the bus is busy and 1 means it is free. A node that comes up while another master is already in the middle of a transfer has missed that START. For that reason a separate ready output stays low after reset until a programmable holdoff has expired. The holdoff should be set to cover the longest transfer the system can produce. The host should not start a transfer of its own before ready is high.

Top module: `i2c_busy_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, bus_free_o is 1, ready_o is 0, and start_o and stop_o are 0.
- R2: SDA going from 1 to 0 while SCL is 1 in both synchronised samples is a START. It raises start_o for exactly one cycle, in the cycle after the second rising clock edge that follows the line change. In the next cycle bus_free_o is 0.
- R3: SDA going from 0 to 1 while SCL is 1 in both synchronised samples is a STOP. It raises stop_o for exactly one cycle, with the same latency as R2. In the next cycle bus_free_o is 1.
- R4: An SDA change while SCL is 0, or in the same sample as an SCL change, produces no pulse and leaves bus_free_o unchanged.
- R5: A START detected while bus_free_o is already 0 (a repeated START) still pulses start_o, and bus_free_o stays 0.
- R6: For a holdoff length N, ready_o is 0 until the max(N,1)-th rising clock edge after reset release. From that edge on it is 1 until the next reset. holdoff_len_i must be held stable during the holdoff.
- R7: A START detected during the holdoff clears bus_free_o exactly as it would once ready_o is 1.
- R8: bus_free_o changes only in the cycle after a start_o or stop_o pulse, and start_o and stop_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| holdoff_len_i | input | HOLD_W | Startup holdoff length in clock cycles |
| bus_free_o | output | 1 | 1 = bus free, 0 = bus busy |
| ready_o | output | 1 | Startup holdoff has expired |
| start_o | output | 1 | One-cycle START pulse |
| stop_o | output | 1 | One-cycle STOP pulse |

## Verification
The bench builds the block with HOLD_W = 6. This makes the largest holdoff, 63 cycles, short enough to run to its end, so the saturating corner of the counter is exercised. The holdoff is run with lengths 0, 20 and 63. The zero case checks the one-edge minimum of R6. Random line activity is checked cycle by cycle against a bench model built from R2 to R5 and R8. Directed sequences place a START inside the holdoff and a repeated START between START and STOP.

// File: rtl/i2c_busy_pkg.sv
package i2c_busy_pkg;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned LINE_CNT    = 2;
  localparam int unsigned LINE_SCL   = 0;
  localparam int unsigned LINE_SDA   = 1;
endpackage

// File: rtl/i2c_busy_sync.sv
module i2c_busy_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_busy_cond.sv
module i2c_busy_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic bus_free_o
);
  logic scl_q, sda_q, free_q, scl_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // SCL must be high in both samples, so an SDA change together with an SCL edge is ignored
  assign scl_hi  = scl_s_i & scl_q;
  assign start_o = scl_hi &  sda_q & ~sda_s_i;
  assign stop_o  = scl_hi & ~sda_q &  sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      free_q <= 1'b1;
    else if (start_o) free_q <= 1'b0;
    else if (stop_o)  free_q <= 1'b1;
  end

  assign bus_free_o = free_q;
endmodule

// File: rtl/i2c_busy_holdoff.sv
module i2c_busy_holdoff #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] len_i,
  output logic         ready_o
);
  localparam int unsigned CW = W + 1;

  logic [W-1:0]  cnt_q;
  logic          done_q;
  logic [CW-1:0] next_cnt;

  assign next_cnt = {1'b0, cnt_q} + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= next_cnt[W-1:0];
      if (next_cnt >= {1'b0, len_i}) done_q <= 1'b1;
    end
  end

  assign ready_o = done_q;
endmodule

// File: rtl/i2c_busy_mon.sv
module i2c_busy_mon
  import i2c_busy_pkg::*;
#(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [HOLD_W-1:0] holdoff_len_i,
  output logic              bus_free_o,
  output logic              ready_o,
  output logic              start_o,
  output logic              stop_o
);
  logic [LINE_CNT-1:0] raw, synced;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  i2c_busy_sync #(.W(LINE_CNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  i2c_busy_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (synced[LINE_SCL]),
    .sda_s_i   (synced[LINE_SDA]),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .bus_free_o(bus_free_o)
  );

  i2c_busy_holdoff #(.W(HOLD_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (holdoff_len_i),
    .ready_o(ready_o)
  );
endmodule

// File: rtl/i2c_busy_mon_chk.sv
module i2c_busy_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_free_o,
  input logic ready_o,
  input logic start_o,
  input logic stop_o
);
  a_r1_reset_free: assert property (@(posedge clk_i) !rst_ni |=> bus_free_o && !ready_o);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !bus_free_o);
  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r3_stop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> bus_free_o);
  a_r3_stop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  a_r6_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  a_r8_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && !stop_o) |=> $stable(bus_free_o));
endmodule

bind i2c_busy_mon i2c_busy_mon_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_free_o(bus_free_o),
  .ready_o   (ready_o),
  .start_o   (start_o),
  .stop_o    (stop_o)
);

// File: tb/test_i2c_busy_mon.sv
module test_i2c_busy_mon;
  localparam int unsigned HW = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [HW-1:0] hlen = '0;
  logic bus_free, ready, start, stop;

  int checks = 0, errors = 0;
  int edge_n = 0, n_start = 0;
  logic [1:0] last = 2'b11, p1 = 2'b11, p2 = 2'b11;  // {scl,sda}
  logic mfree = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_busy_mon #(.HOLD_W(HW)) i_i2c_busy_mon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .holdoff_len_i(hlen), .bus_free_o(bus_free), .ready_o(ready),
    .start_o(start), .stop_o(stop)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at time %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_start(logic [1:0] n, logic [1:0] o);
    return n[1] & o[1] & o[0] & ~n[0];
  endfunction
  function automatic logic f_stop(logic [1:0] n, logic [1:0] o);
    return n[1] & o[1] & ~o[0] & n[0];
  endfunction

  // one cycle: sample after the edge, compare to model, drive the next line values
  task automatic step(input logic s_scl, input logic s_sda);
    logic es, ep;
    @(negedge clk);
    edge_n++;
    es = f_start(p1, p2);
    ep = f_stop(p1, p2);
    chk(es ? "R2 start" : (ep ? "R4 start" : "R4 start"), start, es);
    chk(ep ? "R3 stop" : "R4 stop", stop, ep);
    chk("R8 flag", bus_free, mfree);
    chk("R6 ready", ready, (edge_n >= ((hlen == 0) ? 1 : int'(hlen))));
    if (es) begin mfree = 1'b0; n_start++; end
    else if (ep) mfree = 1'b1;
    p2 = p1; p1 = last; last = {s_scl, s_sda};
    scl = s_scl; sda = s_sda;
  endtask

  task automatic do_reset(input logic [HW-1:0] n);
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; hlen = n;
    last = 2'b11; p1 = 2'b11; p2 = 2'b11; mfree = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 free in reset", bus_free, 1'b1);
    chk("R1 ready in reset", ready, 1'b0);
    rst_n = 1'b1;
    edge_n = 0;
    #1;
    chk("R1 start", start, 1'b0);
    chk("R1 stop", stop, 1'b0);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step(last[1], last[0]);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // holdoff 20, START inside holdoff, repeated START, STOP
    do_reset(6'd20);
    step(1, 1); step(1, 0); settle(3);
    chk("R7 busy while not ready", bus_free, 1'b0);
    chk("R7 not ready yet", ready, 1'b0);
    step(0, 0); step(0, 1); step(1, 1); step(1, 0); settle(3);
    chk("R5 repeated start pulsed", logic'(n_start == 2), 1'b1);
    chk("R5 flag stays busy", bus_free, 1'b0);
    step(0, 0); step(1, 0); step(1, 1); settle(3);
    chk("R3 free after stop", bus_free, 1'b1);
    // SDA toggles with SCL low
    step(0, 1); step(0, 0); step(0, 1); step(0, 0); settle(3);
    chk("R4 no effect scl low", bus_free, 1'b1);
    // simultaneous SCL rise and SDA fall
    step(1, 1); settle(2); step(0, 1); step(1, 0); settle(3);
    chk("R4 no effect simultaneous", bus_free, 1'b1);
    settle(15);
    chk("R6 ready after 20", ready, 1'b1);
    // random line activity
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      if (r == 0)      step(~last[1], last[0]);
      else if (r == 1) step(last[1], ~last[0]);
      else if (r == 2) step(last[1], last[0]);
      else             step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    // holdoff of zero: ready after first edge
    do_reset(6'd0);
    settle(4);
    // largest holdoff
    do_reset(6'd63);
    step(1, 0); settle(70);
    chk("R6 max holdoff reached", ready, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule